// File: doc/BRIEF.md
# Programmable Asynchronous Serial Character Transmitter

This block turns parallel characters into an asynchronous serial frame. A one-entry holding stage accepts a byte over a valid/ready handshake. The shifter takes it when idle and sends a low start bit, then 5 to 8 data bits with the least significant bit first. An optional odd or even parity bit and a high stop period follow. All bit timing comes from a 16x baud tick that is supplied from outside, so one bit lasts `TICKS_PER_BIT` tick pulses.

The character format is set by three line-control inputs: a 2-bit length code, a 2-bit parity code and a 1-bit stop code. The shifter samples these when a frame starts. A break input drives the transmit output low. In loopback mode the external pin is parked high and the frame is sent on a separate internal return line instead. Two status outputs report a frame in progress and a fully drained transmitter.

Top module: `serial_char_tx`

## Requirements
- R1: After synchronous reset, `ser_out` and `loop_out` are high, `busy` is low, and `tx_empty` and `tx_ready` are high.
- R2: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low while a byte is held and not yet taken by the shifter. A held byte is not changed by further input.
- R3: A frame begins on the clock edge after the idle shifter finds a held byte. It sends a start bit at level 0, then the data bits least significant first, then the stop period at level 1. Every start, data and parity bit lasts 16 tick pulses.
- R4: Length code 0, 1, 2 and 3 selects 5, 6, 7 and 8 data bits. Bits of the byte above the selected length are never sent.
- R5: Parity code bit 0 enables a parity bit after the data, and bit 1 selects even (1) or odd (0). With odd parity the count of ones over the data and parity bits is odd, and with even parity it is even. Code 2 sends no parity bit.
- R6: Stop code 0 gives a 16-tick stop period. Stop code 1 gives 32 ticks, except with length code 0, where it gives 24 ticks.
- R7: The format inputs are sampled when a frame starts. Changing them during a frame does not affect that frame.
- R8: `busy` is high from the first start-bit cycle until the stop period ends. `tx_empty` is high only when no byte is held and `busy` is low.
- R9: While `brk_en` is high, the transmit output is low, whether a frame is running or not. The shifter keeps its timing underneath, and the line resumes the frame when `brk_en` falls.
- R10: While `loop_en` is high, `ser_out` is held high and `loop_out` carries the transmit output (including break). While `loop_en` is low, `loop_out` is high.
- R11: A byte held during a frame starts its own start bit exactly one clock after the previous stop period ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_16x | input | 1 | One-cycle pulse at 16 times the baud rate |
| len_code | input | 2 | Data length select (0..3 = 5..8 bits) |
| par_code | input | 2 | Parity select: bit 0 enable, bit 1 even |
| stop_code | input | 1 | 0 = one stop bit, 1 = two (1.5 for 5-bit characters) |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Holding stage can accept a byte |
| brk_en | input | 1 | Force the transmit output low |
| loop_en | input | 1 | Route the frame to `loop_out` and park `ser_out` high |
| ser_out | output | 1 | External serial line |
| loop_out | output | 1 | Internal loopback line |
| busy | output | 1 | A frame is being shifted out |
| tx_empty | output | 1 | No byte held and the shifter is idle |

## Verification
The bench builds the block with its default of 16 ticks per bit and pulses the tick once every three clocks. At that spacing the clock-level alignment between a held byte, the one-cycle gap after a stop period, and tick arrival is visible, and the 24-tick case divides evenly into one and a half bits. A behavioural model compares every output on every clock for each length, parity and stop combination. It also covers back-to-back bytes, format changes during a frame, and break and loopback applied both during a frame and while idle.

// File: rtl/sct_pkg.sv
package sct_pkg;

    localparam int CHAR_W   = 8;
    localparam int MIN_BITS = 5;
    localparam int IDX_W    = 4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_e;

    typedef enum logic [1:0] {
        STOP_ONE,
        STOP_ONEHALF,
        STOP_TWO
    } stop_e;

    typedef struct packed {
        logic [IDX_W-1:0] nbits;
        logic             par_en;
        logic             par_even;
        stop_e            stop_kind;
    } fmt_t;

    function automatic fmt_t decode_fmt(input logic [1:0] len_c,
                                        input logic [1:0] par_c,
                                        input logic       stop_c);
        fmt_t f;
        f.nbits    = IDX_W'(MIN_BITS) + IDX_W'(len_c);
        f.par_en   = par_c[0];
        f.par_even = par_c[1];
        if (!stop_c)
            f.stop_kind = STOP_ONE;
        else if (len_c == 2'd0)
            f.stop_kind = STOP_ONEHALF;
        else
            f.stop_kind = STOP_TWO;
        return f;
    endfunction

    function automatic logic calc_parity(input logic [CHAR_W-1:0] d,
                                         input fmt_t f);
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < CHAR_W; i++) begin
            if (i < int'(f.nbits))
                acc = acc ^ d[i];
        end
        return f.par_even ? acc : ~acc;
    endfunction

    function automatic int stop_ticks(input stop_e k, input int tpb);
        case (k)
            STOP_ONEHALF: return tpb + tpb / 2;
            STOP_TWO:     return 2 * tpb;
            default:      return tpb;
        endcase
    endfunction

endpackage

// File: rtl/sct_hold.sv
module sct_hold
    import sct_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_data,
    input  logic              take,
    output logic              ready,
    output logic              full,
    output logic [CHAR_W-1:0] data
);

    logic              full_q;
    logic [CHAR_W-1:0] data_q;

    assign ready = !full_q;
    assign full  = full_q;
    assign data  = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (take) begin
            full_q <= 1'b0;
        end else if (in_valid && !full_q) begin
            full_q <= 1'b1;
            data_q <= in_data;
        end
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (full_q && !take) |=> (full_q && $stable(data_q))) else $error("hold changed"); // R2

endmodule

// File: rtl/sct_shifter.sv
module sct_shifter
    import sct_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              hold_full,
    input  logic [CHAR_W-1:0] hold_data,
    input  fmt_t              fmt_in,
    output logic              take,
    output logic              frame_line,
    output logic              active
);

    localparam int CNT_W = $clog2(2 * TICKS_PER_BIT + 1);

    phase_e            phase_q;
    logic [CHAR_W-1:0] shreg_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              par_q;
    fmt_t              fmt_q;
    logic [CNT_W-1:0]  dur;
    logic              bit_end;

    assign take   = (phase_q == PH_IDLE) && hold_full;
    assign active = (phase_q != PH_IDLE);

    always_comb begin
        if (phase_q == PH_STOP)
            dur = CNT_W'(stop_ticks(fmt_q.stop_kind, TICKS_PER_BIT));
        else
            dur = CNT_W'(TICKS_PER_BIT);
    end

    assign bit_end = tick && (cnt_q == dur - CNT_W'(1));

    always_comb begin
        case (phase_q)
            PH_START: frame_line = 1'b0;
            PH_DATA:  frame_line = shreg_q[0];
            PH_PAR:   frame_line = par_q;
            default:  frame_line = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            shreg_q <= '0;
            idx_q   <= '0;
            cnt_q   <= '0;
            par_q   <= 1'b0;
            fmt_q   <= '0;
        end else if (take) begin
            phase_q <= PH_START;
            shreg_q <= hold_data;
            idx_q   <= '0;
            cnt_q   <= '0;
            par_q   <= calc_parity(hold_data, fmt_in);
            fmt_q   <= fmt_in;
        end else if (active && tick) begin
            if (bit_end) begin
                cnt_q <= '0;
                case (phase_q)
                    PH_START: phase_q <= PH_DATA;
                    PH_DATA: begin
                        shreg_q <= shreg_q >> 1;
                        idx_q   <= idx_q + IDX_W'(1);
                        if (idx_q == fmt_q.nbits - IDX_W'(1))
                            phase_q <= fmt_q.par_en ? PH_PAR : PH_STOP;
                    end
                    PH_PAR:  phase_q <= PH_STOP;
                    default: phase_q <= PH_IDLE;
                endcase
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        take |=> (active && !frame_line)) else $error("no start bit"); // R3

    AST_FMT_HELD: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active)) |-> $stable(fmt_q)) else $error("format moved"); // R7

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt_q < dur)) else $error("tick count overran"); // R6

    AST_STOP_LAST: assert property (@(posedge clk) disable iff (rst)
        (!active && $past(active) && !$past(rst)) |-> ($past(phase_q) == PH_STOP))
        else $error("frame ended outside stop"); // R3

endmodule

// File: rtl/sct_line_mux.sv
module sct_line_mux (
    input  logic frame_line,
    input  logic brk_en,
    input  logic loop_en,
    output logic ser_out,
    output logic loop_out
);

    logic tx_level;

    assign tx_level = brk_en ? 1'b0 : frame_line;
    assign ser_out  = loop_en ? 1'b1 : tx_level;
    assign loop_out = loop_en ? tx_level : 1'b1;

endmodule

// File: rtl/serial_char_tx.sv
module serial_char_tx
    import sct_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_16x,
    input  logic [1:0]        len_code,
    input  logic [1:0]        par_code,
    input  logic              stop_code,
    input  logic [CHAR_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    input  logic              brk_en,
    input  logic              loop_en,
    output logic              ser_out,
    output logic              loop_out,
    output logic              busy,
    output logic              tx_empty
);

    fmt_t              fmt_live;
    logic              take;
    logic              hold_full;
    logic [CHAR_W-1:0] hold_data;
    logic              frame_line;
    logic              active;

    assign fmt_live = decode_fmt(len_code, par_code, stop_code);

    sct_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .in_valid (tx_valid),
        .in_data  (tx_data),
        .take     (take),
        .ready    (tx_ready),
        .full     (hold_full),
        .data     (hold_data)
    );

    sct_shifter #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_16x),
        .hold_full  (hold_full),
        .hold_data  (hold_data),
        .fmt_in     (fmt_live),
        .take       (take),
        .frame_line (frame_line),
        .active     (active)
    );

    sct_line_mux u_mux (
        .frame_line (frame_line),
        .brk_en     (brk_en),
        .loop_en    (loop_en),
        .ser_out    (ser_out),
        .loop_out   (loop_out)
    );

    assign busy     = active;
    assign tx_empty = !hold_full && !active;

    AST_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> (!busy && tx_ready)) else $error("empty while occupied"); // R8

    AST_LOOP_EXT_HIGH: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> ser_out) else $error("pin moved in loopback"); // R10

    AST_BRK_LOW: assert property (@(posedge clk) disable iff (rst)
        (brk_en && !loop_en) |-> !ser_out) else $error("break not low"); // R9

    AST_READY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        take |=> (busy && tx_ready)) else $error("take did not free hold"); // R11

endmodule

// File: tb/serial_char_tx_bench.sv
module serial_char_tx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TPB        = 16;
    localparam int TICK_GAP   = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_16x = 1'b0;
    logic [1:0] len_code = 2'd3;
    logic [1:0] par_code = 2'd0;
    logic       stop_code = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       brk_en = 1'b0;
    logic       loop_en = 1'b0;
    logic       tx_ready, ser_out, loop_out, busy, tx_empty;

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R1";

    serial_char_tx #(.TICKS_PER_BIT(TPB)) u_serial_char_tx (
        .clk(clk), .rst(rst), .tick_16x(tick_16x),
        .len_code(len_code), .par_code(par_code), .stop_code(stop_code),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .brk_en(brk_en), .loop_en(loop_en),
        .ser_out(ser_out), .loop_out(loop_out), .busy(busy), .tx_empty(tx_empty)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // tick generator: one pulse every TICK_GAP clocks, driven at the falling edge
    int tick_div = 0;
    always @(negedge clk) begin
        tick_div = (tick_div + 1) % TICK_GAP;
        tick_16x = (tick_div == 0);
    end

    // behavioural reference model
    bit   m_full = 0;
    bit   m_active = 0;
    logic [7:0] m_byte = 0;
    bit   lv[$];
    int   du[$];
    int   m_cnt = 0;

    task automatic build_frame(input logic [7:0] d);
        int nb, ones, sdur;
        nb = int'(len_code) + 5;
        ones = 0;
        lv.delete(); du.delete();
        lv.push_back(1'b0); du.push_back(TPB);
        for (int i = 0; i < nb; i++) begin
            lv.push_back(d[i]); du.push_back(TPB);
            ones += int'(d[i]);
        end
        if (par_code[0]) begin
            lv.push_back(par_code[1] ? bit'(ones % 2) : bit'((ones % 2) == 0));
            du.push_back(TPB);
        end
        if (!stop_code) sdur = TPB;
        else if (len_code == 2'd0) sdur = TPB + TPB / 2;
        else sdur = 2 * TPB;
        lv.push_back(1'b1); du.push_back(sdur);
    endtask

    always @(posedge clk) begin
        bit take_now, acc_now;
        if (rst) begin
            m_full = 0; m_active = 0; m_cnt = 0;
            lv.delete(); du.delete();
        end else begin
            take_now = !m_active && m_full;
            acc_now  = tx_valid && !m_full;
            if (m_active && tick_16x) begin
                m_cnt++;
                if (m_cnt == du[0]) begin
                    void'(lv.pop_front()); void'(du.pop_front());
                    m_cnt = 0;
                    if (lv.size() == 0) m_active = 0;
                end
            end
            if (take_now) begin
                build_frame(m_byte);
                m_active = 1; m_cnt = 0; m_full = 0;
            end
            if (acc_now) begin
                m_full = 1; m_byte = tx_data;
            end
        end
    end

    task automatic chk(input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison, two time units after each rising edge
    bit cmp_on = 0;
    always @(posedge clk) begin
        bit fl, txl;
        #2;
        if (cmp_on) begin
            fl  = m_active ? lv[0] : 1'b1;
            txl = brk_en ? 1'b0 : fl;
            chk("ser_out",  ser_out,  loop_en ? 1'b1 : txl);
            chk("loop_out", loop_out, loop_en ? txl : 1'b1);
            chk("busy",     busy,     m_active);
            chk("tx_empty", tx_empty, !m_full && !m_active);
            chk("tx_ready", tx_ready, !m_full);
        end
    end

    task automatic send(input logic [7:0] d);
        @(negedge clk);
        tx_valid = 1'b1; tx_data = d;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0; tx_data = 8'hxx;
        tx_data = ~d;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!tx_empty) @(negedge clk);
        repeat (5) @(negedge clk);
    endtask

    task automatic fmt(input logic [1:0] l, input logic [1:0] p, input logic s);
        @(negedge clk);
        len_code = l; par_code = p; stop_code = s;
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cur_req = "R1";
        chk("reset ser_out", ser_out, 1'b1);
        chk("reset loop_out", loop_out, 1'b1);
        chk("reset busy", busy, 1'b0);
        chk("reset tx_empty", tx_empty, 1'b1);
        chk("reset tx_ready", tx_ready, 1'b1);
        cmp_on = 1;

        cur_req = "R3";
        fmt(2'd3, 2'd0, 1'b0); send(8'hA5); wait_idle();
        send(8'h01); wait_idle();

        cur_req = "R4";
        fmt(2'd0, 2'd0, 1'b0); send(8'hFF); wait_idle();
        fmt(2'd1, 2'd0, 1'b0); send(8'hE6); wait_idle();
        fmt(2'd2, 2'd0, 1'b0); send(8'h9C); wait_idle();

        cur_req = "R5";
        fmt(2'd3, 2'd1, 1'b0); send(8'h37); wait_idle();
        fmt(2'd3, 2'd1, 1'b0); send(8'h33); wait_idle();
        fmt(2'd3, 2'd3, 1'b0); send(8'h37); wait_idle();
        fmt(2'd0, 2'd3, 1'b0); send(8'hE1); wait_idle();
        fmt(2'd3, 2'd2, 1'b0); send(8'h5A); wait_idle();

        cur_req = "R6";
        fmt(2'd3, 2'd0, 1'b1); send(8'h81); wait_idle();
        fmt(2'd0, 2'd0, 1'b1); send(8'h15); wait_idle();
        fmt(2'd1, 2'd1, 1'b1); send(8'h2A); wait_idle();

        cur_req = "R7";
        fmt(2'd3, 2'd0, 1'b0); send(8'hC3);
        repeat (60) @(negedge clk);
        len_code = 2'd0; par_code = 2'd3; stop_code = 1'b1;
        wait_idle();

        cur_req = "R2";
        fmt(2'd3, 2'd0, 1'b0);
        @(negedge clk);
        tx_valid = 1'b1; tx_data = 8'h11;
        @(negedge clk);
        tx_data = 8'h22;
        chk("ready low after accept", tx_ready, 1'b0);
        @(negedge clk);
        tx_data = 8'h33;
        repeat (40) @(negedge clk);
        tx_valid = 1'b0;
        wait_idle();

        cur_req = "R11";
        send(8'h6B); send(8'h94); send(8'h0F); wait_idle();

        cur_req = "R8";
        fmt(2'd2, 2'd1, 1'b1); send(8'h7E); wait_idle();

        cur_req = "R9";
        @(negedge clk); brk_en = 1'b1;
        repeat (20) @(negedge clk); brk_en = 1'b0;
        fmt(2'd3, 2'd3, 1'b0); send(8'hAA);
        repeat (100) @(negedge clk); brk_en = 1'b1;
        repeat (70) @(negedge clk); brk_en = 1'b0;
        wait_idle();

        cur_req = "R10";
        @(negedge clk); loop_en = 1'b1;
        send(8'h5C);
        repeat (150) @(negedge clk); brk_en = 1'b1;
        repeat (30) @(negedge clk); brk_en = 1'b0;
        wait_idle();
        loop_en = 1'b0;
        send(8'h3D); wait_idle();
        cmp_on = 0;
    endtask

    initial begin
        bit timed_out;
        timed_out = 0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
        end
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule